// File: doc/BRIEF.md
# Write Strobe Qualification Guard

This block decides whether a write strobe from a byte-wide memory bus may start an internal write cycle. It takes the active-low chip enable, output enable and write enable pins straight from the bus. It also takes a digital flag from a supply comparator that reports whether the supply is above its write threshold. From these it produces one clean, single-clock write-start pulse for the write engine that follows it.

All four inputs are first passed through a synchronizer chain. The supply flag drives a holdoff counter. Writes stay blocked until the supply has been good for a programmable number of clocks, and any dip of the flag restarts that count. A write strobe is active while chip enable and write enable are both low, so a write can be controlled by either pin. The strobe is qualified only when output enable is high and the holdoff has elapsed. A width filter then counts clocks while the qualified strobe stays low. The start pulse is issued only when the strobe has been low for a minimum number of clocks, which rejects short glitches. After that, no further pulse is issued until the strobe goes inactive again.

The default holdoff of 1,000,000 clocks matches about 5 ms at 200 MHz. The default minimum width of 3 clocks matches about 15 ns at the same rate.

Top module: `wsq_guard`

## Requirements
- R1: During reset and right after it, `wr_start_o` is 0 and the holdoff has not elapsed, so a strobe given at once produces no pulse.
- R2: While `supply_ok_i` is 0, no strobe of any length produces a pulse.
- R3: After the synchronized supply flag rises, writes stay blocked for HOLDOFF_CYCLES clocks. A strobe that lies wholly inside that window produces no pulse, and a strobe given after it produces one.
- R4: A drop of the supply flag, even a short one, restarts the whole holdoff from zero.
- R5: While output enable (`oe_n_i`) is 0, a strobe produces no pulse.
- R6: The strobe is active only while both `ce_n_i` and `we_n_i` are 0. Either pin may be the one that pulses (write-enable-controlled or chip-enable-controlled). Write enable low with chip enable high produces no pulse.
- R7: A strobe that is active for fewer than MIN_LOW_CYCLES consecutive synchronized clocks produces no pulse. A strobe of exactly MIN_LOW_CYCLES clocks produces one.
- R8: `wr_start_o` is high for exactly one clock. When the pins first become qualifying just before clock edge e, it rises after edge e + SYNC_STAGES + MIN_LOW_CYCLES - 1.
- R9: A strobe held for any length of time yields at most one pulse. Another pulse needs the strobe to go inactive (ce_n or we_n high) for at least one synchronized clock, and back-to-back strobes separated in this way each yield a pulse.
- R10: Every input passes through SYNC_STAGES flip-flops before it is used. The reset values are supply bad and all control pins high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok_i | input | 1 | Supply comparator flag, 1 = supply above write threshold |
| ce_n_i | input | 1 | Raw chip enable, active low |
| oe_n_i | input | 1 | Raw output enable, active low; low inhibits writes |
| we_n_i | input | 1 | Raw write enable, active low |
| wr_start_o | output | 1 | Single-clock qualified write-start pulse |

## Verification
The bench drives strobes of exactly MIN_LOW_CYCLES and of one clock less, and checks the clock in which each pulse appears. A filter that is off by one would either accept the short glitch or reject the legal minimum, and a wrong pipeline depth would show as a shifted pulse. Strobes are also given while the holdoff is still running, both after power-up and after a brief supply dip. A design that did not restart its counter on the dip would issue a pulse there. Long held strobes, strobes with output enable low, and write enable low with chip enable high are checked too. These catch a pulse that repeats every MIN_LOW_CYCLES and a decode that ignores one of the inhibit pins.

// File: rtl/wsq_pkg.sv
package wsq_pkg;

  // Width needed to hold counts 0..max_val
  function automatic int unsigned cnt_width(input int unsigned max_val);
    int unsigned w;
    w = $clog2(max_val + 1);
    return (w < 1) ? 1 : w;
  endfunction

  // Write strobe is active while both chip enable and write enable are low
  function automatic logic strobe_active(input logic ce_n, input logic we_n);
    return (!ce_n) && (!we_n);
  endfunction

  // A strobe may count toward a write only with output enable high and power settled
  function automatic logic write_permitted(input logic strobe, input logic oe_n,
                                           input logic pwr_ready);
    return strobe && oe_n && pwr_ready;
  endfunction

  // Bit order of the synchronized control bundle
  typedef struct packed {
    logic supply_ok;
    logic ce_n;
    logic oe_n;
    logic we_n;
  } ctl_pins_t;

  localparam ctl_pins_t CTL_RESET = '{supply_ok: 1'b0, ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1};

endpackage

// File: rtl/wsq_sync.sv
module wsq_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 4,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain[g] <= RST_VAL;
        end else begin
          if (g == 0) chain[g] <= d_i;
          else        chain[g] <= chain[(g == 0) ? 0 : g - 1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];

endmodule

// File: rtl/wsq_holdoff.sv
module wsq_holdoff
  import wsq_pkg::*;
#(
  parameter int unsigned HOLDOFF_CYCLES = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok_s,
  output logic pwr_ready_o
);

  localparam int unsigned CW = cnt_width(HOLDOFF_CYCLES);
  localparam logic [CW-1:0] LIMIT = CW'(HOLDOFF_CYCLES);

  logic [CW-1:0] hold_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt_q <= '0;
    end else if (!supply_ok_s) begin
      hold_cnt_q <= '0;
    end else if (hold_cnt_q != LIMIT) begin
      hold_cnt_q <= hold_cnt_q + 1'b1;
    end
  end

  assign pwr_ready_o = (hold_cnt_q == LIMIT);

  // R4
  supply_drop_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok_s |=> (hold_cnt_q == '0) && !pwr_ready_o);

  // R3
  holdoff_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_cnt_q <= LIMIT);

  // R3
  ready_needs_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_ready_o |-> $past(supply_ok_s));

endmodule

// File: rtl/wsq_filter.sv
module wsq_filter
  import wsq_pkg::*;
#(
  parameter int unsigned MIN_LOW_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  input  logic permit_i,
  output logic wr_start_o
);

  localparam int unsigned CW = cnt_width(MIN_LOW_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(MIN_LOW_CYCLES - 1);

  logic [CW-1:0] low_cnt_q;
  logic          fired_q;
  logic          wr_start_q;
  logic          width_met;
  logic          fire_now;

  assign width_met = (low_cnt_q == LAST);
  assign fire_now  = permit_i && !fired_q && width_met;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt_q  <= '0;
      fired_q    <= 1'b0;
      wr_start_q <= 1'b0;
    end else begin
      wr_start_q <= fire_now;
      if (!permit_i)       low_cnt_q <= '0;
      else if (!width_met) low_cnt_q <= low_cnt_q + 1'b1;
      if (fire_now)        fired_q <= 1'b1;
      else if (!strobe_i)  fired_q <= 1'b0;
    end
  end

  assign wr_start_o = wr_start_q;

  // R8
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start_q |=> !wr_start_q);

  // R9
  one_per_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start_q |-> !$past(fired_q));

  // R7
  width_before_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start_q |-> $past(width_met) && $past(permit_i));

endmodule

// File: rtl/wsq_guard.sv
module wsq_guard
  import wsq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES    = 2,
  parameter int unsigned HOLDOFF_CYCLES = 1000000,
  parameter int unsigned MIN_LOW_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok_i,
  input  logic ce_n_i,
  input  logic oe_n_i,
  input  logic we_n_i,
  output logic wr_start_o
);

  localparam int unsigned CTL_W = $bits(ctl_pins_t);

  ctl_pins_t raw_pins;
  ctl_pins_t sync_pins;
  logic      strobe_s;
  logic      oe_s;
  logic      power_ready;
  logic      permit;

  assign raw_pins = '{supply_ok: supply_ok_i, ce_n: ce_n_i, oe_n: oe_n_i, we_n: we_n_i};

  // R10
  wsq_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (CTL_W),
    .RST_VAL(CTL_RESET)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (raw_pins),
    .q_o  (sync_pins)
  );

  wsq_holdoff #(
    .HOLDOFF_CYCLES(HOLDOFF_CYCLES)
  ) u_holdoff (
    .clk        (clk),
    .rst_n      (rst_n),
    .supply_ok_s(sync_pins.supply_ok),
    .pwr_ready_o(power_ready)
  );

  assign strobe_s = strobe_active(sync_pins.ce_n, sync_pins.we_n);
  assign oe_s     = sync_pins.oe_n;
  assign permit   = write_permitted(strobe_s, oe_s, power_ready);

  wsq_filter #(
    .MIN_LOW_CYCLES(MIN_LOW_CYCLES)
  ) u_filter (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe_i  (strobe_s),
    .permit_i  (permit),
    .wr_start_o(wr_start_o)
  );

  // R2
  start_needs_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start_o |-> $past(sync_pins.supply_ok));

  // R3
  start_after_holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start_o |-> $past(power_ready));

  // R5
  start_needs_oe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start_o |-> $past(oe_s));

  // R6
  start_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start_o |-> $past(strobe_s));

endmodule

// File: tb/wsq_guard_tb.sv
`timescale 1ns/1ps
module wsq_guard_tb;

  localparam int unsigned S    = 2;
  localparam int unsigned HOLD = 64;
  localparam int unsigned MINL = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0;
  logic ce_n = 1'b1;
  logic oe_n = 1'b1;
  logic we_n = 1'b1;
  logic wr_start;

  int   cyc = 0;
  int   n_checks = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  int   exp_q[$];
  string req_q[$];
  string cur_req = "R1";

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wsq_guard #(
    .SYNC_STAGES   (S),
    .HOLDOFF_CYCLES(HOLD),
    .MIN_LOW_CYCLES(MINL)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .supply_ok_i(supply_ok),
    .ce_n_i     (ce_n),
    .oe_n_i     (oe_n),
    .we_n_i     (we_n),
    .wr_start_o (wr_start)
  );

  // Monitor: compare each observed pulse against the scoreboard
  always @(negedge clk) begin
    if (rst_n && wr_start && !done) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL %s: unexpected pulse at cycle %0d, expected none", cur_req, cyc);
      end else begin
        int e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        if (e != cyc) begin
          n_fail++;
          $display("FAIL %s: pulse at cycle %0d, expected cycle %0d", r, cyc, e);
        end
      end
    end
  end

  // Driver: pulse ce (ce_ctrl=1) or we (ce_ctrl=0) low for n clocks, other pin held low
  task automatic strobe(input int n, input bit ce_ctrl, input bit expect_pulse,
                        input string req);
    cur_req = req;
    @(negedge clk);
    if (ce_ctrl) we_n = 1'b0; else ce_n = 1'b0;
    repeat (2) @(negedge clk);
    if (expect_pulse) begin
      exp_q.push_back(cyc + S + MINL);
      req_q.push_back(req);
    end
    if (ce_ctrl) ce_n = 1'b0; else we_n = 1'b0;
    repeat (n) @(negedge clk);
    ce_n = 1'b1;
    we_n = 1'b1;
    repeat (S + MINL + 4) @(negedge clk);
  endtask

  task automatic drained(input string req);
    n_checks++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL %s: %0d expected pulse(s) missing, expected 0", req, exp_q.size());
      exp_q.delete();
      req_q.delete();
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual timeout, expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (4) @(negedge clk);
    n_checks++;
    if (wr_start !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: wr_start during reset %b, expected 0", wr_start);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    n_checks++;
    if (wr_start !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: wr_start after reset %b, expected 0", wr_start);
    end

    // R2: supply bad, long strobe
    strobe(10, 1'b0, 1'b0, "R2");
    drained("R2");

    // R3: supply good, strobe inside holdoff
    @(negedge clk);
    supply_ok = 1'b1;
    strobe(10, 1'b0, 1'b0, "R3");
    drained("R3");
    repeat (HOLD + 10) @(negedge clk);

    // R7 / R8: exact minimum width, WE-controlled
    strobe(MINL, 1'b0, 1'b1, "R7");
    drained("R7");
    strobe(MINL + 1, 1'b0, 1'b1, "R8");
    drained("R8");
    // R7: one clock short, and a single-clock glitch
    strobe(MINL - 1, 1'b0, 1'b0, "R7");
    drained("R7");
    strobe(1, 1'b1, 1'b0, "R7");
    drained("R7");

    // R6: CE-controlled write
    strobe(MINL + 2, 1'b1, 1'b1, "R6");
    drained("R6");
    // R6: WE low with CE high
    cur_req = "R6";
    @(negedge clk);
    we_n = 1'b0;
    repeat (12) @(negedge clk);
    we_n = 1'b1;
    repeat (6) @(negedge clk);
    drained("R6");

    // R5: OE low inhibits
    @(negedge clk);
    oe_n = 1'b0;
    strobe(10, 1'b0, 1'b0, "R5");
    oe_n = 1'b1;
    drained("R5");

    // R9: long strobe gives exactly one pulse
    strobe(25, 1'b0, 1'b1, "R9");
    drained("R9");
    // R9: two strobes separated by release each give a pulse
    strobe(MINL, 1'b1, 1'b1, "R9");
    strobe(MINL, 1'b0, 1'b1, "R9");
    drained("R9");

    // R4: brief supply dip restarts holdoff
    @(negedge clk);
    supply_ok = 1'b0;
    repeat (2) @(negedge clk);
    supply_ok = 1'b1;
    strobe(10, 1'b0, 1'b0, "R4");
    drained("R4");
    repeat (HOLD + 10) @(negedge clk);
    strobe(MINL, 1'b1, 1'b1, "R4");
    drained("R4");

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule